// File: doc/BRIEF.md
# March Memory Test Sequencer

This block is a self-test engine for a synchronous single-port RAM. After a start pulse it takes over the RAM's address, write-enable and write-data pins. It then walks every address through one of three march algorithms. Each algorithm is a fixed list of elements. An element is a short run of write and read operations applied at every address before the next element begins, and it counts addresses either upward or downward. The engine predicts the value every read should return and compares it with the RAM output one cycle later. A mismatch raises a fail flag that stays set, and the address and element number of the first mismatch are kept.

The three algorithms come from one table of element op-codes and run on a single engine. They are March Y, March LR, and March LR extended with two-bit background words. The memory side is a plain synchronous RAM port with no back-pressure: the RAM accepts one operation every cycle, and a read returns its data in the next cycle. For that reason no valid/ready handshake is used. Control (start, algorithm select) and status (busy, done, fail) are plain level pins.

Top module: `march_seq_top`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fail_o` and `mem_we_o` are all low.
- R2: A `start_i` high at a clock edge while the engine is idle or done is accepted. `alg_sel_i` is sampled at that edge and `busy_o` is high from the next cycle. A `start_i` that arrives while `busy_o` is high has no effect on the operation stream.
- R3: While running, exactly one RAM operation is issued per cycle. A run of an algorithm with K operations per address leaves `busy_o` high for K*DEPTH+1 cycles, and `done_o` rises at the edge K*DEPTH+1 cycles after the accepting edge.
- R4: Select 0, and also select 3, run March Y: up(w0); up(r0,w1,r1); down(r1,w0,r0); up(r0). That is 8 operations per address, elements numbered 0 to 3.
- R5: Select 1 runs March LR: up(w0); down(r0,w1); up(r1,w0,r0,r0,w1); up(r1,w0); up(r0,w1,r1,r1,w0); up(r0). That is 16 operations per address, elements 0 to 5.
- R6: Select 2 runs the six March LR elements with backgrounds 00/11. It then runs up(r00,w01,w10,r10), up(r10,w01,r01) and up(r01) as elements 6 to 8, for 24 operations per address.
- R7: Data words are built as follows. Value 0 gives all zeros. Value 1 gives all ones. Pattern 01 sets every even-numbered bit, so an 8-bit word is 0x55. Pattern 10 sets every odd-numbered bit, so an 8-bit word is 0xAA.
- R8: The RAM's data is compared in the cycle after the read address is presented. On a fault-free RAM, no run sets `fail_o`.
- R9: The first mismatch sets `fail_o` and loads `fail_addr_o` and `fail_elem_o`. These three hold unchanged until the next accepted start, which clears `fail_o`.
- R10: `done_o` stays high from the end of a run until the next accepted start. It is never high together with `busy_o`.
- R11: Ascending elements visit addresses 0 up to DEPTH-1. Descending elements visit DEPTH-1 down to 0. All operations of an element are applied at one address before the address moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| alg_sel_i | input | 2 | Algorithm select (0/3 March Y, 1 March LR, 2 March LR with backgrounds) |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished, held until next start |
| mem_addr_o | output | ADDR_W | RAM address |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | DATA_W | RAM write data |
| mem_rdata_i | input | DATA_W | RAM read data, one cycle after address |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | ADDR_W | Address of first mismatch |
| fail_elem_o | output | 4 | Element index of first mismatch |

## Verification
Some properties are checked by assertions on every cycle:
- writes only occur while busy;
- busy and done never overlap, and busy always ends in done;
- the address counter never steps past the end of its range in either direction;
- the fail flag and its captured address stay put until a new start.

Other behaviour can only be shown by the bench scenarios. These are the exact order of operations and data words for each algorithm, the address direction of each element, the total run length, and that injected stuck-at and coupling faults are caught at the predicted address and element while clean memories pass.

// File: rtl/march_pkg.sv
package march_pkg;
  localparam int ELEM_W = 4;
  localparam int OPS_MAX = 5;

  // op code: bit 2 = write, bits 1:0 = data pattern (0 zeros, 1 ones, 2 even bits, 3 odd bits)
  typedef logic [2:0] mop_t;
  localparam mop_t OP_R0  = 3'b000;
  localparam mop_t OP_R1  = 3'b001;
  localparam mop_t OP_R01 = 3'b010;
  localparam mop_t OP_R10 = 3'b011;
  localparam mop_t OP_W0  = 3'b100;
  localparam mop_t OP_W1  = 3'b101;
  localparam mop_t OP_W01 = 3'b110;
  localparam mop_t OP_W10 = 3'b111;

  typedef struct packed {
    logic                    down;
    logic                    last;
    logic [2:0]              nops;
    mop_t [OPS_MAX-1:0]      ops;
  } elem_t;

  function automatic elem_t mk_elem(logic dn, logic lst, logic [2:0] n,
                                    mop_t a, mop_t b, mop_t c, mop_t d, mop_t e);
    elem_t r;
    r.down = dn;
    r.last = lst;
    r.nops = n;
    r.ops  = {e, d, c, b, a};
    return r;
  endfunction

  function automatic elem_t y_elem(logic [ELEM_W-1:0] idx);
    case (idx)
      4'd0:    return mk_elem(1'b0, 1'b0, 3'd1, OP_W0, OP_R0, OP_R0, OP_R0, OP_R0);
      4'd1:    return mk_elem(1'b0, 1'b0, 3'd3, OP_R0, OP_W1, OP_R1, OP_R0, OP_R0);
      4'd2:    return mk_elem(1'b1, 1'b0, 3'd3, OP_R1, OP_W0, OP_R0, OP_R0, OP_R0);
      default: return mk_elem(1'b0, 1'b1, 3'd1, OP_R0, OP_R0, OP_R0, OP_R0, OP_R0);
    endcase
  endfunction

  function automatic elem_t lr_elem(logic [ELEM_W-1:0] idx, logic fin);
    case (idx)
      4'd0:    return mk_elem(1'b0, 1'b0, 3'd1, OP_W0, OP_R0, OP_R0, OP_R0, OP_R0);
      4'd1:    return mk_elem(1'b1, 1'b0, 3'd2, OP_R0, OP_W1, OP_R0, OP_R0, OP_R0);
      4'd2:    return mk_elem(1'b0, 1'b0, 3'd5, OP_R1, OP_W0, OP_R0, OP_R0, OP_W1);
      4'd3:    return mk_elem(1'b0, 1'b0, 3'd2, OP_R1, OP_W0, OP_R0, OP_R0, OP_R0);
      4'd4:    return mk_elem(1'b0, 1'b0, 3'd5, OP_R0, OP_W1, OP_R1, OP_R1, OP_W0);
      default: return mk_elem(1'b0, fin,  3'd1, OP_R0, OP_R0, OP_R0, OP_R0, OP_R0);
    endcase
  endfunction

  function automatic elem_t bg_elem(logic [ELEM_W-1:0] idx);
    if (idx < 4'd6) return lr_elem(idx, 1'b0);
    case (idx)
      4'd6:    return mk_elem(1'b0, 1'b0, 3'd4, OP_R0, OP_W01, OP_W10, OP_R10, OP_R0);
      4'd7:    return mk_elem(1'b0, 1'b0, 3'd3, OP_R10, OP_W01, OP_R01, OP_R0, OP_R0);
      default: return mk_elem(1'b0, 1'b1, 3'd1, OP_R01, OP_R0, OP_R0, OP_R0, OP_R0);
    endcase
  endfunction

  function automatic elem_t march_elem(logic [1:0] alg, logic [ELEM_W-1:0] idx);
    case (alg)
      2'd1:    return lr_elem(idx, 1'b1);
      2'd2:    return bg_elem(idx);
      default: return y_elem(idx);
    endcase
  endfunction
endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic              ld_down_i,
  input  logic              step_i,
  input  logic              dir_down_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              at_end_o
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (ld_i)   addr_q <= ld_down_i ? ADDR_MAX : '0;
    else if (step_i) addr_q <= dir_down_i ? addr_q - 1'b1 : addr_q + 1'b1;
  end

  assign addr_o   = addr_q;
  assign at_end_o = dir_down_i ? (addr_q == '0) : (addr_q == ADDR_MAX);

  assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> !at_end_o);
  assert_ld_step_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_i && step_i));
endmodule

// File: rtl/march_ctrl.sv
module march_ctrl
  import march_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        alg_i,
  input  logic              at_end_i,
  output logic              ld_o,
  output logic              ld_down_o,
  output logic              step_o,
  output logic              dir_down_o,
  output logic              issue_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [ELEM_W-1:0] elem_o,
  output logic              clear_o,
  output logic              busy_o,
  output logic              done_o
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_DONE} st_e;

  st_e               st_q;
  logic [1:0]        alg_q;
  logic [ELEM_W-1:0] elem_q;
  logic [2:0]        op_q;
  elem_t             cur, nxt, first;
  mop_t              cur_op;
  logic              accept, in_run, last_op;

  function automatic logic [DATA_W-1:0] pat_word(logic [1:0] p);
    logic [DATA_W-1:0] w;
    for (int i = 0; i < DATA_W; i++)
      w[i] = (p == 2'd1) || (p == 2'd2 && (i % 2) == 0) || (p == 2'd3 && (i % 2) == 1);
    return w;
  endfunction

  always_comb begin
    cur    = march_elem(alg_q, elem_q);
    nxt    = march_elem(alg_q, elem_q + 1'b1);
    first  = march_elem(alg_i, '0);
    cur_op = cur.ops[op_q];
  end

  assign accept  = start_i && (st_q == S_IDLE || st_q == S_DONE);
  assign in_run  = (st_q == S_RUN);
  assign last_op = (op_q == cur.nops - 3'd1);

  assign ld_o       = accept || (in_run && last_op && at_end_i && !cur.last);
  assign ld_down_o  = accept ? first.down : nxt.down;
  assign step_o     = in_run && last_op && !at_end_i;
  assign dir_down_o = cur.down;
  assign issue_o    = in_run;
  assign we_o       = in_run && cur_op[2];
  assign wdata_o    = pat_word(cur_op[1:0]);
  assign elem_o     = elem_q;
  assign clear_o    = accept;
  assign busy_o     = in_run || (st_q == S_DRAIN);
  assign done_o     = (st_q == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      alg_q  <= '0;
      elem_q <= '0;
      op_q   <= '0;
    end else if (accept) begin
      st_q   <= S_RUN;
      alg_q  <= alg_i;
      elem_q <= '0;
      op_q   <= '0;
    end else begin
      case (st_q)
        S_RUN: begin
          if (last_op) begin
            op_q <= '0;
            if (at_end_i) begin
              if (cur.last) st_q <= S_DRAIN;
              else          elem_q <= elem_q + 1'b1;
            end
          end else begin
            op_q <= op_q + 1'b1;
          end
        end
        S_DRAIN: st_q <= S_DONE;
        default: st_q <= st_q;
      endcase
    end
  end

  assert_we_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> busy_o);
  assert_done_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));
  assert_busy_ends_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int ELEM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              rd_issue_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ELEM_W-1:0] elem_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [ELEM_W-1:0] fail_elem_o
);
  logic              pend_q;
  logic [DATA_W-1:0] exp_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ELEM_W-1:0] elem_q;
  logic              fail_q;
  logic [ADDR_W-1:0] faddr_q;
  logic [ELEM_W-1:0] felem_q;
  logic              miss;

  // stage aligned with the one-cycle RAM read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      exp_q  <= '0;
      addr_q <= '0;
      elem_q <= '0;
    end else begin
      pend_q <= rd_issue_i;
      if (rd_issue_i) begin
        exp_q  <= exp_i;
        addr_q <= addr_i;
        elem_q <= elem_i;
      end
    end
  end

  assign miss = pend_q && (rdata_i != exp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      faddr_q <= '0;
      felem_q <= '0;
    end else if (clear_i) begin
      fail_q  <= 1'b0;
    end else if (miss && !fail_q) begin
      fail_q  <= 1'b1;
      faddr_q <= addr_q;
      felem_q <= elem_q;
    end
  end

  assign fail_o      = fail_q;
  assign fail_addr_o = faddr_q;
  assign fail_elem_o = felem_q;

  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q && !clear_i |=> fail_q);
  assert_fail_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q && !clear_i |=> $stable(faddr_q) && $stable(felem_q));
endmodule

// File: rtl/march_seq_top.sv
module march_seq_top
  import march_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        alg_sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [3:0]        fail_elem_o
);
  logic              ld, ld_down, step, dir_down, at_end, issue, we, clear;
  logic [DATA_W-1:0] wdata;
  logic [ELEM_W-1:0] elem;
  logic [ADDR_W-1:0] addr;

  march_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .alg_i(alg_sel_i),
    .at_end_i(at_end), .ld_o(ld), .ld_down_o(ld_down), .step_o(step),
    .dir_down_o(dir_down), .issue_o(issue), .we_o(we), .wdata_o(wdata),
    .elem_o(elem), .clear_o(clear), .busy_o(busy_o), .done_o(done_o)
  );

  march_addr_gen #(.ADDR_W(ADDR_W)) addr_i (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .ld_down_i(ld_down), .step_i(step),
    .dir_down_i(dir_down), .addr_o(addr), .at_end_o(at_end)
  );

  march_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ELEM_W(ELEM_W)) cmp_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .rd_issue_i(issue && !we),
    .exp_i(wdata), .addr_i(addr), .elem_i(elem), .rdata_i(mem_rdata_i),
    .fail_o(fail_o), .fail_addr_o(fail_addr_o), .fail_elem_o(fail_elem_o)
  );

  assign mem_addr_o  = addr;
  assign mem_we_o    = we;
  assign mem_wdata_o = wdata;
endmodule

// File: tb/march_seq_top_tb_top.sv
`timescale 1ns/1ps
module march_seq_top_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  // bench op codes: bit2 write, bits1:0 pattern (R7)
  localparam int R0 = 0, R1 = 1, R01 = 2, R10 = 3, W0 = 4, W1 = 5, W01 = 6, W10 = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] alg = 2'd0;
  logic busy, done, we, fail;
  logic [AW-1:0] addr, faddr;
  logic [DW-1:0] wdata, rdata;
  logic [3:0] felem;

  int total = 0, bad = 0;

  march_seq_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .alg_sel_i(alg),
    .busy_o(busy), .done_o(done), .mem_addr_o(addr), .mem_we_o(we),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .fail_o(fail),
    .fail_addr_o(faddr), .fail_elem_o(felem)
  );

  always #2.5 clk = ~clk;

  // ---------------- RAM model with faults ----------------
  int fmode = 0; // 0 none, 1 stuck-at-1 a5.b2, 2 coupling a3.b0 rise flips a9.b0, 3 stuck-at-0 a12.b7
  logic [DW-1:0] ram [N];
  logic [DW-1:0] pm  [N];

  task automatic mwrite(bit pred, int a, logic [DW-1:0] d);
    logic [DW-1:0] old, st;
    old = pred ? pm[a] : ram[a];
    st  = d;
    if (fmode == 1 && a == 5)  st[2] = 1'b1;
    if (fmode == 3 && a == 12) st[7] = 1'b0;
    if (fmode == 2 && a == 3 && !old[0] && d[0]) begin
      if (pred) pm[9][0] = ~pm[9][0];
      else      ram[9][0] = ~ram[9][0];
    end
    if (pred) pm[a] = st;
    else      ram[a] = st;
  endtask

  always @(posedge clk) begin
    rdata <= ram[addr];
    if (we) mwrite(1'b0, int'(addr), wdata);
  end

  // ---------------- reference element tables ----------------
  bit el_down [16];
  int el_n    [16];
  int el_op   [16][5];
  int el_cnt;

  task automatic add_el(bit d, int n, int a, int b, int c, int e, int f);
    el_down[el_cnt] = d; el_n[el_cnt] = n;
    el_op[el_cnt][0] = a; el_op[el_cnt][1] = b; el_op[el_cnt][2] = c;
    el_op[el_cnt][3] = e; el_op[el_cnt][4] = f;
    el_cnt++;
  endtask

  task automatic build_alg(int a);
    el_cnt = 0;
    if (a == 1 || a == 2) begin // R5
      add_el(0, 1, W0, 0, 0, 0, 0);
      add_el(1, 2, R0, W1, 0, 0, 0);
      add_el(0, 5, R1, W0, R0, R0, W1);
      add_el(0, 2, R1, W0, 0, 0, 0);
      add_el(0, 5, R0, W1, R1, R1, W0);
      add_el(0, 1, R0, 0, 0, 0, 0);
      if (a == 2) begin // R6
        add_el(0, 4, R0, W01, W10, R10, 0);
        add_el(0, 3, R10, W01, R01, 0, 0);
        add_el(0, 1, R01, 0, 0, 0, 0);
      end
    end else begin // R4
      add_el(0, 1, W0, 0, 0, 0, 0);
      add_el(0, 3, R0, W1, R1, 0, 0);
      add_el(1, 3, R1, W0, R0, 0, 0);
      add_el(0, 1, R0, 0, 0, 0, 0);
    end
  endtask

  function automatic logic [DW-1:0] pw(int p);
    logic [DW-1:0] w;
    for (int i = 0; i < DW; i++)
      w[i] = (p == 1) || (p == 2 && i % 2 == 0) || (p == 3 && i % 2 == 1);
    return w;
  endfunction

  // ---------------- scoreboard ----------------
  typedef struct { bit w; int a; logic [DW-1:0] d; } exp_t;
  exp_t q[$];
  bit pfail; int paddr, pelem;

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic predict();
    pfail = 0; paddr = 0; pelem = 0;
    for (int e = 0; e < el_cnt; e++)
      for (int j = 0; j < N; j++) begin
        int a;
        a = el_down[e] ? N - 1 - j : j; // R11
        for (int o = 0; o < el_n[e]; o++) begin
          int op;
          op = el_op[e][o];
          if (op >= 4) begin
            q.push_back('{1'b1, a, pw(op & 3)});
            mwrite(1'b1, a, pw(op & 3));
          end else begin
            q.push_back('{1'b0, a, '0});
            if (pm[a] !== pw(op & 3) && !pfail) begin
              pfail = 1; paddr = a; pelem = e;
            end
          end
        end
      end
  endtask

  // monitor: one RAM operation per cycle must match the queue head (R3, R7, R11)
  always @(negedge clk) begin
    if (rst_n && busy) begin
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(we == e.w, "R3", "op kind", we, e.w);
        check(int'(addr) == e.a, "R11", "address", addr, e.a);
        if (e.w) check(wdata == e.d, "R7", "write data", wdata, e.d);
      end else if (we) begin
        check(1'b0, "R3", "extra write", 1, 0);
      end
    end
  end

  task automatic run(int a, int fm, bit expect_det, bit poke, string req);
    int ops, k;
    fmode = fm;
    for (int i = 0; i < N; i++) begin ram[i] = DW'(8'h3C ^ i); pm[i] = DW'(8'h3C ^ i); end
    build_alg(a);
    predict();
    ops = q.size();
    @(negedge clk);
    start = 1'b1; alg = 2'(a);
    @(negedge clk);
    start = 1'b0; alg = 2'(a ^ 1);
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    check(fail == 1'b0, "R9", "fail cleared by start", fail, 0);
    k = 1;
    while (!done && k < 2000) begin
      @(negedge clk);
      k++;
      start = (poke && k == 6); // R2: start while busy must be ignored
    end
    start = 1'b0;
    check(k == ops + 2, "R3", "cycles to done", k, ops + 2);
    check(q.size() == 0, "R3", "ops left", q.size(), 0);
    check(fail == pfail, req, "fail flag (R8)", fail, pfail);
    check(fail == expect_det, req, "detection", fail, expect_det);
    if (pfail) begin
      check(int'(faddr) == paddr, "R9", "fail addr", faddr, paddr);
      check(int'(felem) == pelem, "R9", "fail elem", felem, pelem);
    end
    repeat (4) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R10", "done held", done, 1);
    check(fail == pfail, "R9", "fail sticky", fail, pfail);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !we, "R1", "reset state",
          {busy, done, fail, we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !fail && !we, "R1", "idle after reset",
          {busy, done, fail, we}, 0);
    run(0, 0, 0, 0, "R4");
    run(1, 0, 0, 1, "R5");
    run(2, 0, 0, 0, "R6");
    run(3, 0, 0, 0, "R4");
    run(0, 1, 1, 0, "R4");
    run(1, 2, 1, 0, "R5");
    run(2, 3, 1, 1, "R6");
    run(0, 2, 1, 0, "R4");
    run(2, 0, 0, 0, "R6");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule